// File: doc/BRIEF.md
# Mode Register Set Timing Guard

This block sits between a memory controller's command scheduler and a DDR3-style command bus. It handles mode register set (MRS) commands. The scheduler raises an MRS request with a bank-select value and an address opcode. The guard drives the MRS onto the bus only when every bank reports idle and no data burst is running. Until then the request waits behind a low `mrs_ready`, and it is never dropped.

After an MRS, the guard closes the command path for the mode-update delay. During that time it drives only NOP on the bus and holds on-die termination low. It also holds clock enable high until the power-down entry delay has elapsed. Both delays are clock-cycle counts taken from static configuration inputs, and both count from the cycle the MRS is on the bus. `mode_busy` marks the cycles in which the mode register is still being updated. A one-cycle `mode_done` pulse marks the first cycle in which the new setting is in effect. If an upstream block tries to force a real command through the closed window, a sticky flag records the attempt.

Outside these windows, the block passes scheduler commands, ODT and CKE requests to the bus with one register stage.

Top module: `mrs_guard`

## Requirements
- R1: The block grants an MRS request (`mrs_ready`=1) only in a cycle where all `bank_idle` bits are 1 and `burst_active` is 0. Otherwise `mrs_ready` stays 0 and the request waits until the scheduler withdraws it.
- R2: Commands use the 4-bit encoding {cs_n, ras_n, cas_n, we_n}: MRS=0000, NOP=0111, deselect=1111, ACT=0011. Let M be the MRS bus cycle and T the value of `cfg_tmod`, with 0 treated as 1. Then bus cycles M+1 to M+T-1 carry NOP, `cmd_ready` is 0 in cycles M-1 to M+T-2, and an upstream command can appear on the bus no earlier than cycle M+T.
- R3: `bus_odt` is 0 in bus cycles M to M+T-1, whatever `odt_req` is.
- R4: Let P be `cfg_tpden`, with 0 treated as 1. `bus_cke` is 1 in bus cycles M to M+P-1, whatever `cke_req` is.
- R5: A grant in cycle G drives MRS on `bus_cmd` in cycle G+1 for one cycle. `bus_ba` carries `mrs_ba` and `bus_addr` carries `mrs_op` as sampled in cycle G.
- R6: `mode_busy` is 1 in bus cycles M to M+T-1. `mode_done` is 1 for exactly the one cycle M+T.
- R7: A request with `cmd_valid`, `cmd_force` and a command other than NOP or deselect, made while the window of R2 is closed, sets `force_viol` in the next cycle. The flag stays set until reset, and the bus still carries NOP. The same request made while the path is open leaves `force_viol` at 0.
- R8: When an MRS grant and a scheduler command compete in the same cycle, the MRS wins and `cmd_ready` is 0.
- R9: Synchronous active-high reset gives `bus_cmd`=deselect, `bus_cke`=1, `bus_odt`=0, `mode_busy`=0, `mode_done`=0 and `force_viol`=0.
- R10: Outside the windows above, an accepted command appears on the bus in the next cycle with its bank and address. A cycle with no accepted command or grant shows deselect in the next cycle. `bus_odt` and `bus_cke` follow `odt_req` and `cke_req` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tmod | input | CW | Mode-update delay in cycles |
| cfg_tpden | input | CW | Power-down entry delay in cycles |
| bank_idle | input | NB | Per-bank idle (precharged, precharge delay met) |
| burst_active | input | 1 | A data burst is in progress |
| mrs_req | input | 1 | MRS request |
| mrs_ba | input | BAW | Mode register select |
| mrs_op | input | AW | Mode register opcode |
| mrs_ready | output | 1 | MRS request granted this cycle |
| cmd_valid | input | 1 | Scheduler command valid |
| cmd_code | input | 4 | Scheduler command encoding |
| cmd_ba | input | BAW | Scheduler bank address |
| cmd_addr | input | AW | Scheduler address |
| cmd_force | input | 1 | Scheduler insists on issuing |
| cmd_ready | output | 1 | Scheduler command accepted |
| odt_req | input | 1 | Requested ODT level |
| cke_req | input | 1 | Requested CKE level |
| bus_cmd | output | 4 | Registered command bus |
| bus_ba | output | BAW | Registered bank address |
| bus_addr | output | AW | Registered address |
| bus_odt | output | 1 | Registered ODT |
| bus_cke | output | 1 | Registered CKE |
| mode_busy | output | 1 | Mode register update in progress |
| mode_done | output | 1 | New setting takes effect (pulse) |
| force_viol | output | 1 | Sticky forced-command violation |

## Verification
The bench checks exact cycle counts at the end of each window, where an off-by-one error would let the first ACT, a raised ODT or a dropped CKE appear one cycle early or late. It programs a zero mode-update delay to check that the block treats it as one cycle; a design that did not would either wrap its counter or never release the bus. It checks that an MRS request is blocked by each precondition in turn and still issues once both clear, that a same-cycle command loses to the MRS, and that a force attempt sets the flag only inside the window and that the flag survives until reset. A long random run compares every bus cycle against the command, opcode, ODT and CKE the bench expects from the previous cycle's handshake.

// File: rtl/mrs_guard_pkg.sv
package mrs_guard_pkg;
  typedef logic [3:0] cmd_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam cmd_t CMD_DES = 4'b1111;
  localparam cmd_t CMD_NOP = 4'b0111;
  localparam cmd_t CMD_MRS = 4'b0000;

  localparam int NUM_DLY = 2;
  localparam int DLY_MOD = 0;
  localparam int DLY_PDEN = 1;

  function automatic logic cmd_is_quiet(cmd_t c);
    return c[3] || (c == CMD_NOP);
  endfunction
endpackage

// File: rtl/mrs_delay_cnt.sv
module mrs_delay_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          active,
  output logic          last
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] start_val;

  // A programmed length of zero behaves as one cycle
  assign start_val = (len == '0) ? '0 : len - CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (load) begin
      active <= 1'b1;
      cnt    <= start_val;
    end else if (active) begin
      if (cnt == '0) begin
        active <= 1'b0;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  assign last = active && (cnt == '0);
endmodule

// File: rtl/mrs_precheck.sv
module mrs_precheck #(
  parameter int NB = 8
) (
  input  logic [NB-1:0] bank_idle,
  input  logic          burst_active,
  output logic          ok
);
  logic [NB:0] chain;

  assign chain[0] = 1'b1;
  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign chain[b+1] = chain[b] & bank_idle[b];
  end

  assign ok = chain[NB] & ~burst_active;
endmodule

// File: rtl/mrs_bus_reg.sv
module mrs_bus_reg
  import mrs_guard_pkg::*;
#(
  parameter int AW  = 14,
  parameter int BAW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  cmd_t           nxt_cmd,
  input  logic [BAW-1:0] nxt_ba,
  input  logic [AW-1:0]  nxt_addr,
  input  logic           nxt_odt,
  input  logic           nxt_cke,
  output cmd_t           bus_cmd,
  output logic [BAW-1:0] bus_ba,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_odt,
  output logic           bus_cke
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_cmd  <= CMD_DES;
      bus_ba   <= '0;
      bus_addr <= '0;
      bus_odt  <= 1'b0;
      bus_cke  <= 1'b1;
    end else begin
      bus_cmd  <= nxt_cmd;
      bus_ba   <= nxt_ba;
      bus_addr <= nxt_addr;
      bus_odt  <= nxt_odt;
      bus_cke  <= nxt_cke;
    end
  end
endmodule

// File: rtl/mrs_guard.sv
module mrs_guard
  import mrs_guard_pkg::*;
#(
  parameter int NB  = 8,
  parameter int BAW = 3,
  parameter int AW  = 14,
  parameter int CW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [CW-1:0]  cfg_tmod,
  input  logic [CW-1:0]  cfg_tpden,
  input  logic [NB-1:0]  bank_idle,
  input  logic           burst_active,
  input  logic           mrs_req,
  input  logic [BAW-1:0] mrs_ba,
  input  logic [AW-1:0]  mrs_op,
  output logic           mrs_ready,
  input  logic           cmd_valid,
  input  logic [3:0]     cmd_code,
  input  logic [BAW-1:0] cmd_ba,
  input  logic [AW-1:0]  cmd_addr,
  input  logic           cmd_force,
  output logic           cmd_ready,
  input  logic           odt_req,
  input  logic           cke_req,
  output logic [3:0]     bus_cmd,
  output logic [BAW-1:0] bus_ba,
  output logic [AW-1:0]  bus_addr,
  output logic           bus_odt,
  output logic           bus_cke,
  output logic           mode_busy,
  output logic           mode_done,
  output logic           force_viol
);
  logic               pre_ok;
  logic               grant;
  logic               closed;
  logic               cmd_go;
  logic [CW-1:0]      dly_len [NUM_DLY];
  logic [NUM_DLY-1:0] dly_act;
  logic [NUM_DLY-1:0] dly_last;
  logic [NUM_DLY-1:0] dly_hold;

  cmd_t           nxt_cmd;
  logic [BAW-1:0] nxt_ba;
  logic [AW-1:0]  nxt_addr;
  logic           nxt_odt;
  logic           nxt_cke;

  mrs_precheck #(.NB(NB)) u_pre (
    .bank_idle    (bank_idle),
    .burst_active (burst_active),
    .ok           (pre_ok)
  );

  assign dly_len[DLY_MOD]  = cfg_tmod;
  assign dly_len[DLY_PDEN] = cfg_tpden;

  for (genvar d = 0; d < NUM_DLY; d++) begin : g_dly
    mrs_delay_cnt #(.CW(CW)) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .load   (grant),
      .len    (dly_len[d]),
      .active (dly_act[d]),
      .last   (dly_last[d])
    );
    assign dly_hold[d] = dly_act[d] & ~dly_last[d];
  end

  assign closed    = dly_hold[DLY_MOD];
  assign grant     = mrs_req && pre_ok && !closed;
  assign mrs_ready = grant;
  assign cmd_ready = !closed && !grant;
  assign cmd_go    = cmd_valid && cmd_ready;

  always_comb begin
    nxt_cmd  = CMD_DES;
    nxt_ba   = '0;
    nxt_addr = '0;
    if (grant) begin
      nxt_cmd  = CMD_MRS;
      nxt_ba   = mrs_ba;
      nxt_addr = mrs_op;
    end else if (closed) begin
      nxt_cmd  = CMD_NOP;
    end else if (cmd_go) begin
      nxt_cmd  = cmd_code;
      nxt_ba   = cmd_ba;
      nxt_addr = cmd_addr;
    end
  end

  assign nxt_odt = odt_req && !grant && !closed;
  assign nxt_cke = cke_req || grant || dly_hold[DLY_PDEN];

  mrs_bus_reg #(.AW(AW), .BAW(BAW)) u_bus (
    .clk      (clk),
    .rst      (rst),
    .nxt_cmd  (nxt_cmd),
    .nxt_ba   (nxt_ba),
    .nxt_addr (nxt_addr),
    .nxt_odt  (nxt_odt),
    .nxt_cke  (nxt_cke),
    .bus_cmd  (bus_cmd),
    .bus_ba   (bus_ba),
    .bus_addr (bus_addr),
    .bus_odt  (bus_odt),
    .bus_cke  (bus_cke)
  );

  assign mode_busy = dly_act[DLY_MOD];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_done  <= 1'b0;
      force_viol <= 1'b0;
    end else begin
      mode_done  <= dly_last[DLY_MOD] && !grant;
      if (cmd_valid && cmd_force && closed && !cmd_is_quiet(cmd_code)) begin
        force_viol <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mrs_guard_chk.sv
module mrs_guard_chk
  import mrs_guard_pkg::*;
#(
  parameter int NB  = 8,
  parameter int BAW = 3,
  parameter int AW  = 14,
  parameter int CW  = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [CW-1:0]  cfg_tmod,
  input logic [CW-1:0]  cfg_tpden,
  input logic [NB-1:0]  bank_idle,
  input logic           burst_active,
  input logic [BAW-1:0] mrs_ba,
  input logic [AW-1:0]  mrs_op,
  input logic           mrs_ready,
  input logic [3:0]     bus_cmd,
  input logic [BAW-1:0] bus_ba,
  input logic [AW-1:0]  bus_addr,
  input logic           bus_odt,
  input logic           bus_cke,
  input logic           mode_busy,
  input logic           mode_done,
  input logic           force_viol
);
  logic [CW:0]   since;
  logic [CW-1:0] tmod_eff;
  logic [CW-1:0] tpden_eff;
  logic          in_mod;
  logic          in_pden;

  assign tmod_eff  = (cfg_tmod == '0) ? CW'(1) : cfg_tmod;
  assign tpden_eff = (cfg_tpden == '0) ? CW'(1) : cfg_tpden;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= '0;
    end else if (bus_cmd == CMD_MRS) begin
      since <= (CW+1)'(1);
    end else if (since != '0 && since != '1) begin
      since <= since + (CW+1)'(1);
    end
  end

  assign in_mod  = (since != '0) && (since < {1'b0, tmod_eff});
  assign in_pden = (since != '0) && (since < {1'b0, tpden_eff});

  // R1
  grant_idle_chk: assert property (@(posedge clk) disable iff (rst)
    mrs_ready |-> ((&bank_idle) && !burst_active));

  // R2
  mod_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (in_mod && bus_cmd != CMD_MRS) |-> (bus_cmd == CMD_NOP));

  // R3
  odt_low_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_cmd == CMD_MRS) || in_mod) |-> !bus_odt);

  // R4
  cke_high_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_cmd == CMD_MRS) || in_pden) |-> bus_cke);

  // R5
  mrs_issue_chk: assert property (@(posedge clk) disable iff (rst)
    mrs_ready |=> (bus_cmd == CMD_MRS && bus_addr == $past(mrs_op) && bus_ba == $past(mrs_ba)));

  // R6
  mode_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd == CMD_MRS) |-> mode_busy);

  // R6
  mode_done_chk: assert property (@(posedge clk) disable iff (rst)
    mode_done |-> (!mode_busy && $past(mode_busy)));

  // R7
  viol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    force_viol |=> force_viol);

  // R9
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (bus_cmd == CMD_DES && bus_cke && !bus_odt && !force_viol && !mode_done));
endmodule

bind mrs_guard mrs_guard_chk #(.NB(NB), .BAW(BAW), .AW(AW), .CW(CW)) u_chk (.*);

// File: tb/tb_mrs_guard.sv
`timescale 1ns/1ps
module tb_mrs_guard;
  localparam int NB = 8;
  localparam int BAW = 3;
  localparam int AW = 14;
  localparam int CW = 8;
  localparam real HALF = 2.0;

  localparam logic [3:0] C_DES = 4'b1111;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_MRS = 4'b0000;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cfg_tmod = 8'd4, cfg_tpden = 8'd7;
  logic [NB-1:0] bank_idle = '1;
  logic burst_active = 1'b0;
  logic mrs_req = 1'b0;
  logic [BAW-1:0] mrs_ba = '0;
  logic [AW-1:0] mrs_op = '0;
  logic mrs_ready;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_code = C_NOP;
  logic [BAW-1:0] cmd_ba = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic cmd_force = 1'b0;
  logic cmd_ready;
  logic odt_req = 1'b0, cke_req = 1'b1;
  logic [3:0] bus_cmd;
  logic [BAW-1:0] bus_ba;
  logic [AW-1:0] bus_addr;
  logic bus_odt, bus_cke, mode_busy, mode_done, force_viol;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  always #(HALF) clk = ~clk;

  mrs_guard #(.NB(NB), .BAW(BAW), .AW(AW), .CW(CW)) dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4.0 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  // expected bus command k cycles after (and including) the MRS cycle, ACT pending
  function automatic logic [3:0] exp_seq_cmd(int j, int tmod);
    int t = (tmod == 0) ? 1 : tmod;
    if (j == 1) return C_MRS;
    if (j <= t) return C_NOP;
    return C_ACT;
  endfunction

  function automatic bit is_quiet(logic [3:0] c);
    return c[3] || c == C_NOP;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    tick(); tick();
    chk(bus_cmd == C_DES, "R9", "bus_cmd", bus_cmd, C_DES);
    chk(bus_cke == 1'b1 && bus_odt == 1'b0, "R9", "cke/odt", {bus_cke, bus_odt}, 2'b10);
    chk(!mode_busy && !mode_done && !force_viol, "R9", "busy/done/viol",
        {mode_busy, mode_done, force_viol}, 0);
    rst = 1'b0;
    tick();
  endtask

  task automatic do_grant(input logic [AW-1:0] op, input logic [BAW-1:0] ba);
    mrs_req = 1'b1; mrs_op = op; mrs_ba = ba;
    #1;
    chk(mrs_ready == 1'b1, "R1", "mrs_ready on idle banks", mrs_ready, 1);
    tick();
    mrs_req = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // random phase state
  int since;
  bit p_mrs, p_go, p_odt, p_cke;
  logic [3:0] p_code;
  logic [AW-1:0] p_addr, p_op;
  logic [BAW-1:0] p_ba, p_mba;

  initial begin
    do_reset();

    // R10: idle deselect, then a pass-through command
    chk(bus_cmd == C_DES, "R10", "idle bus", bus_cmd, C_DES);
    cmd_valid = 1; cmd_code = C_RD; cmd_addr = 14'h0155; cmd_ba = 3'd5;
    #1;
    chk(cmd_ready == 1, "R10", "cmd_ready open", cmd_ready, 1);
    tick();
    cmd_valid = 0;
    chk(bus_cmd == C_RD && bus_addr == 14'h0155 && bus_ba == 3'd5, "R10", "passthrough",
        {bus_cmd, bus_addr}, {C_RD, 14'h0155});
    idle(2);

    // R1: held by a busy bank, then by a burst
    bank_idle = 8'hFE; mrs_req = 1; mrs_op = 14'h0321; mrs_ba = 3'd1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(mrs_ready == 0, "R1", "ready with bank busy", mrs_ready, 0);
      tick();
      chk(bus_cmd != C_MRS, "R1", "no MRS with bank busy", bus_cmd, C_DES);
    end
    bank_idle = '1; burst_active = 1;
    #1;
    chk(mrs_ready == 0, "R1", "ready with burst", mrs_ready, 0);
    tick();
    chk(bus_cmd != C_MRS, "R1", "no MRS with burst", bus_cmd, C_DES);
    burst_active = 0;
    #1;
    chk(mrs_ready == 1, "R1", "ready after release", mrs_ready, 1);
    tick();
    mrs_req = 0;
    chk(bus_cmd == C_MRS && bus_addr == 14'h0321 && bus_ba == 3'd1, "R5", "held MRS issued",
        {bus_cmd, bus_addr}, {C_MRS, 14'h0321});
    idle(12);

    // Full window sequence: tmod=5, tpden=8
    cfg_tmod = 8'd5; cfg_tpden = 8'd8; odt_req = 1; cke_req = 1;
    idle(2);
    do_grant(14'h0A5C, 3'd2);
    cke_req = 0; cmd_valid = 1; cmd_code = C_ACT; cmd_addr = 14'h0123; cmd_ba = 3'd1;
    for (int j = 1; j <= 10; j++) begin
      chk(bus_cmd == exp_seq_cmd(j, 5), "R2", $sformatf("bus_cmd j=%0d", j),
          bus_cmd, exp_seq_cmd(j, 5));
      if (j == 1)
        chk(bus_addr == 14'h0A5C && bus_ba == 3'd2, "R5", "opcode", bus_addr, 14'h0A5C);
      if (j == 2)
        chk(bus_cmd != C_MRS, "R5", "single cycle MRS", bus_cmd, C_NOP);
      chk(bus_odt == (j > 5), "R3", $sformatf("odt j=%0d", j), bus_odt, (j > 5));
      chk(bus_cke == (j <= 8), "R4", $sformatf("cke j=%0d", j), bus_cke, (j <= 8));
      chk(mode_busy == (j <= 5), "R6", $sformatf("busy j=%0d", j), mode_busy, (j <= 5));
      chk(mode_done == (j == 6), "R6", $sformatf("done j=%0d", j), mode_done, (j == 6));
      #1;
      chk(cmd_ready == (j >= 5), "R2", $sformatf("cmd_ready j=%0d", j), cmd_ready, (j >= 5));
      tick();
    end
    cmd_valid = 0; cke_req = 1; odt_req = 0;
    idle(4);

    // R2 boundary: tmod=0 behaves as one cycle
    cfg_tmod = 8'd0; cfg_tpden = 8'd1;
    do_grant(14'h0007, 3'd0);
    cmd_valid = 1; cmd_code = C_ACT;
    chk(bus_cmd == C_MRS, "R2", "tmod0 MRS", bus_cmd, C_MRS);
    #1;
    chk(cmd_ready == 1, "R2", "tmod0 ready", cmd_ready, 1);
    tick();
    chk(bus_cmd == C_ACT, "R2", "tmod0 next cmd", bus_cmd, C_ACT);
    chk(mode_done == 1, "R6", "tmod0 done", mode_done, 1);
    cmd_valid = 0;
    idle(3);

    // R8: MRS beats a same-cycle command
    cfg_tmod = 8'd3;
    mrs_req = 1; mrs_op = 14'h0042; mrs_ba = 3'd3; cmd_valid = 1; cmd_code = C_WR;
    #1;
    chk(mrs_ready == 1 && cmd_ready == 0, "R8", "priority", {mrs_ready, cmd_ready}, 2'b10);
    tick();
    mrs_req = 0; cmd_valid = 0;
    chk(bus_cmd == C_MRS, "R8", "MRS wins", bus_cmd, C_MRS);
    idle(6);

    // R7: force outside the window does nothing, inside sets sticky flag
    cfg_tmod = 8'd6;
    cmd_valid = 1; cmd_force = 1; cmd_code = C_ACT;
    tick();
    cmd_valid = 0; cmd_force = 0;
    chk(force_viol == 0, "R7", "force while open", force_viol, 0);
    chk(bus_cmd == C_ACT, "R7", "forced cmd passes when open", bus_cmd, C_ACT);
    do_grant(14'h0011, 3'd0);
    cmd_valid = 1; cmd_force = 1; cmd_code = C_ACT;
    tick();
    cmd_valid = 0; cmd_force = 0;
    chk(force_viol == 1, "R7", "force in window", force_viol, 1);
    chk(bus_cmd == C_NOP, "R7", "bus still NOP", bus_cmd, C_NOP);
    idle(10);
    chk(force_viol == 1, "R7", "flag sticky", force_viol, 1);
    do_reset();

    // Random phase with fixed seed
    cfg_tmod = 8'd4; cfg_tpden = 8'd7;
    void'($urandom(32'h1234_5678));
    since = 0; p_mrs = 0; p_go = 0; p_odt = odt_req; p_cke = cke_req;
    for (int c = 0; c < 4000; c++) begin
      // check outputs produced by last cycle's inputs
      if (p_mrs)
        chk(bus_cmd == C_MRS && bus_addr == p_op && bus_ba == p_mba, "R5", "rand MRS",
            {bus_cmd, bus_addr}, {C_MRS, p_op});
      else if (p_go)
        chk(bus_cmd == p_code && bus_addr == p_addr && bus_ba == p_ba, "R10", "rand cmd",
            {bus_cmd, bus_addr}, {p_code, p_addr});
      else
        chk(is_quiet(bus_cmd), "R2", "rand quiet", bus_cmd, C_NOP);
      if (bus_cmd == C_MRS || (since != 0 && since < 4)) begin
        chk(!bus_odt, "R3", "rand odt low", bus_odt, 0);
        if (bus_cmd != C_MRS)
          chk(bus_cmd == C_NOP, "R2", "rand window NOP", bus_cmd, C_NOP);
      end else begin
        chk(bus_odt == p_odt, "R10", "rand odt follow", bus_odt, p_odt);
      end
      if (bus_cmd == C_MRS || (since != 0 && since < 7))
        chk(bus_cke, "R4", "rand cke high", bus_cke, 1);
      else
        chk(bus_cke == p_cke, "R10", "rand cke follow", bus_cke, p_cke);
      if (bus_cmd == C_MRS) since = 1;
      else if (since != 0 && since < 1000) since++;

      // new inputs
      if (!mrs_req && ($urandom % 16) == 0) begin
        mrs_req = 1; mrs_op = AW'($urandom); mrs_ba = BAW'($urandom);
      end
      bank_idle = (($urandom % 4) == 0) ? NB'($urandom) : '1;
      burst_active = (($urandom % 5) == 0);
      cmd_valid = (($urandom % 2) == 0);
      case ($urandom % 4)
        0: cmd_code = C_ACT;
        1: cmd_code = C_RD;
        2: cmd_code = C_WR;
        default: cmd_code = C_NOP;
      endcase
      cmd_addr = AW'($urandom); cmd_ba = BAW'($urandom);
      odt_req = $urandom % 2; cke_req = (($urandom % 3) != 0);
      #1;
      if (mrs_ready)
        chk((&bank_idle) && !burst_active, "R1", "rand grant precondition",
            {bank_idle, burst_active}, {NB'('1), 1'b0});
      chk(!(mrs_ready && cmd_ready), "R8", "rand exclusive", {mrs_ready, cmd_ready}, 2'b10);
      p_mrs = mrs_ready; p_op = mrs_op; p_mba = mrs_ba;
      p_go = cmd_valid && cmd_ready; p_code = cmd_code; p_addr = cmd_addr; p_ba = cmd_ba;
      p_odt = odt_req; p_cke = cke_req;
      tick();
      if (p_mrs) mrs_req = 0;
    end
    report();
  end
endmodule